// File: doc/BRIEF.md
# Pixel Keyed Soft Video Switch

This block picks, for every pixel, the sample that drives the composite output. It chooses either the sample from the internal luma/chroma combiner or a sample from an external composite (CVBS) bus. The choice follows a key. The key is the external key pin, ORed with a data-key request that an upstream colour-match stage generates.

The block does not switch hard between the sources. It crossfades over four pixel clocks with a weight that steps through 0, 1/4, 1/2, 3/4 and 1. The key is delayed so that the weight reaches one half exactly on the pixel that entered together with that key value. Outside active video the key is normally forced off, so the encoder's own blanking always reaches the output. A pass-through control lifts this gating. A second control moves the timing of the external key five pixel clocks earlier. Both sample streams are delayed by the same number of pixel clocks as the key decision, so the two sources arrive at the mixer sample-aligned.

Top module: `vsw_soft_key_switch`

## Requirements
- R1: While reset is asserted and on the first clock after it, `comp_o` is 0 and the mix weight is 0.
- R2: With no effective key, `comp_o` equals `enc_i` delayed by ADV_CYC+4 pixel clocks (9 by default).
- R3: With the effective key held on, `comp_o` equals `cvbs_i` delayed by the same ADV_CYC+4 clocks.
- R4: The weight w moves by at most one step of 1/4 per clock and stays between 0 and 4. The output is (w*cvbs + (4-w)*enc + 2) >> 2, so a value at exactly half rounds upward.
- R5: With `adv_i`=0, the weight reaches 2/4 on the output slot of the pixel that entered together with the rising key. On that slot the output is (cvbs+enc+1)>>1 of that pixel.
- R6: With `adv_i`=1, the external key acts five pixel clocks earlier. The half-weight slot belongs to the pixel that entered five clocks before the key.
- R7: With `hw_en_i`=0, `key_i` has no effect on `comp_o`.
- R8: With `pass_i`=0, the key is treated as off for any pixel whose `act_i` was 0. `act_i` travels with the pixel, and the data key is gated the same way.
- R9: With `pass_i`=1, the key is honoured whether or not `act_i` is set, so CVBS blanking reaches the output.
- R10: The data key `dkey_i` is ORed with the enabled hardware key. It switches to CVBS even when `hw_en_i`=0, and it is never advanced.
- R11: If the key reverses in mid-transition, the weight turns back from its current value one step per clock and does not jump.
- R12: Both sample paths carry the same fixed latency in every mode, so arbitrary changes of key, data key, active flag and controls keep the output equal to the cycle model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_i | input | DATA_W | Sample from the luma/chroma combiner |
| cvbs_i | input | DATA_W | Sample from the external composite bus |
| key_i | input | 1 | Raw external key, sampled like a pixel bit |
| dkey_i | input | 1 | Internally generated data-key request |
| act_i | input | 1 | Active-video flag of this pixel |
| hw_en_i | input | 1 | Enables the external key |
| pass_i | input | 1 | Honours the key during blanking |
| adv_i | input | 1 | Moves external key timing ADV_CYC clocks earlier |
| comp_o | output | DATA_W | Crossfaded composite sample |

## Verification
A behavioural cycle model is fed the same random sample streams and compared with `comp_o` on every clock.

Each test pattern separates one thing:
- Steady key-off and key-on runs check the latency of each source on its own.
- Isolated key pulses of one and two pixels place the half-weight slot, which exposes an off-by-one in the key delay.
- Fixed source pairs such as 0/1 and 1023/0 expose errors in the rounding.
- Key toggling at periods of two and three clocks forces reversals mid-ramp.
- Gating is checked by keeping the key high while toggling `act_i`, then repeating with `pass_i` set and with `hw_en_i` cleared.
- Advanced-mode pulses mixed with data-key pulses show that only the external key moves.
- A final run with every control random checks that the latency stays fixed in every mode.

// File: rtl/vsw_pkg.sv
`timescale 1ns/1ps
package vsw_pkg;
   // direction of the crossfade weight in the current clock
   typedef enum logic [1:0] {
      RAMP_HOLD = 2'd0,
      RAMP_UP   = 2'd1,
      RAMP_DOWN = 2'd2
   } ramp_dir_t;

   localparam int DEF_DATA_W  = 10;
   localparam int DEF_STEPS   = 4;
   localparam int DEF_ADV_CYC = 5;
endpackage

// File: rtl/vsw_pipe.sv
`timescale 1ns/1ps
module vsw_pipe #(
   parameter int W = 1,
   parameter int N = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (N < 1) begin : g_bad_depth
      $error("vsw_pipe: N must be at least 1");
   end

   logic [W-1:0] stg [N];

   for (genvar g = 0; g < N; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= d_i;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   assign q_o = stg[N-1];
endmodule

// File: rtl/vsw_keypath.sv
`timescale 1ns/1ps
module vsw_keypath #(
   parameter int ADV_CYC = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_i,
   input  logic dkey_i,
   input  logic act_i,
   input  logic hw_en_i,
   input  logic pass_i,
   input  logic adv_i,
   output logic tgt_o
);
   // bit 2 external key, bit 1 data key, bit 0 active flag
   logic [2:0] cap_r;
   logic [2:0] late_r;
   logic       hw_key;

   // input register: the key is captured like a pixel bit
   vsw_pipe #(.W(3), .N(1)) u_cap (
      .clk(clk), .rst_n(rst_n),
      .d_i({key_i, dkey_i, act_i}), .q_o(cap_r)
   );

   // normal alignment delay
   vsw_pipe #(.W(3), .N(ADV_CYC)) u_late (
      .clk(clk), .rst_n(rst_n),
      .d_i(cap_r), .q_o(late_r)
   );

   // advanced mode taps the external key ADV_CYC stages earlier
   assign hw_key = adv_i ? cap_r[2] : late_r[2];

   assign tgt_o = ((hw_en_i & hw_key) | late_r[1]) & (late_r[0] | pass_i);

   AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (!hw_en_i && !late_r[1]) |-> !tgt_o) else $error("tgt without key source"); // R7
endmodule

// File: rtl/vsw_ramp.sv
`timescale 1ns/1ps
module vsw_ramp
   import vsw_pkg::*;
#(
   parameter int STEPS = 4,
   localparam int WW = $clog2(STEPS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tgt_i,
   output logic [WW-1:0] wt_o
);
   localparam logic [WW-1:0] W_FULL = WW'(STEPS);

   ramp_dir_t dir;

   always_comb begin
      if (tgt_i && wt_o != W_FULL)       dir = RAMP_UP;
      else if (!tgt_i && wt_o != '0)     dir = RAMP_DOWN;
      else                               dir = RAMP_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wt_o <= '0;
      else begin
         case (dir)
            RAMP_UP:   wt_o <= wt_o + WW'(1);
            RAMP_DOWN: wt_o <= wt_o - WW'(1);
            default:   wt_o <= wt_o;
         endcase
      end
   end

   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_i && wt_o != W_FULL) |=> (wt_o == $past(wt_o) + WW'(1))) else $error("ramp up"); // R4
   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!tgt_i && wt_o != '0) |=> (wt_o == $past(wt_o) - WW'(1))) else $error("ramp down"); // R11
   AST_W_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      wt_o <= W_FULL) else $error("weight out of range"); // R4
endmodule

// File: rtl/vsw_blend.sv
`timescale 1ns/1ps
module vsw_blend #(
   parameter int DATA_W  = 10,
   parameter int STEPS   = 4,
   parameter int ADV_CYC = 5,
   localparam int WW = $clog2(STEPS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] enc_i,
   input  logic [DATA_W-1:0] cvbs_i,
   input  logic [WW-1:0]     wt_i,
   output logic [DATA_W-1:0] comp_o
);
   localparam int LOG = $clog2(STEPS);
   localparam int DLY = 1 + ADV_CYC + STEPS / 2;   // matches key path to midpoint
   localparam int PW  = DATA_W + LOG;
   localparam logic [WW-1:0] W_FULL = WW'(STEPS);

   logic [DATA_W-1:0] enc_d, cvbs_d;
   logic [PW-1:0]     acc;

   vsw_pipe #(.W(DATA_W), .N(DLY)) u_enc_dly (
      .clk(clk), .rst_n(rst_n), .d_i(enc_i), .q_o(enc_d)
   );
   vsw_pipe #(.W(DATA_W), .N(DLY)) u_cvbs_dly (
      .clk(clk), .rst_n(rst_n), .d_i(cvbs_i), .q_o(cvbs_d)
   );

   always_comb begin
      acc = PW'(wt_i) * PW'(cvbs_d)
          + PW'(W_FULL - wt_i) * PW'(enc_d)
          + PW'(STEPS / 2);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) comp_o <= '0;
      else        comp_o <= DATA_W'(acc >> LOG);
   end

   AST_SRC_ENC: assert property (@(posedge clk) disable iff (!rst_n)
      (wt_i == '0) |=> (comp_o == $past(enc_d))) else $error("enc pass"); // R2
   AST_SRC_CVBS: assert property (@(posedge clk) disable iff (!rst_n)
      (wt_i == W_FULL) |=> (comp_o == $past(cvbs_d))) else $error("cvbs pass"); // R3
endmodule

// File: rtl/vsw_soft_key_switch.sv
`timescale 1ns/1ps
module vsw_soft_key_switch
   import vsw_pkg::*;
#(
   parameter int DATA_W  = DEF_DATA_W,
   parameter int STEPS   = DEF_STEPS,
   parameter int ADV_CYC = DEF_ADV_CYC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] enc_i,
   input  logic [DATA_W-1:0] cvbs_i,
   input  logic              key_i,
   input  logic              dkey_i,
   input  logic              act_i,
   input  logic              hw_en_i,
   input  logic              pass_i,
   input  logic              adv_i,
   output logic [DATA_W-1:0] comp_o
);
   localparam int WW = $clog2(STEPS + 1);

   if (STEPS < 2 || (STEPS & (STEPS - 1)) != 0) begin : g_bad_steps
      $error("STEPS must be a power of two of at least 2");
   end
   if (ADV_CYC < 1) begin : g_bad_adv
      $error("ADV_CYC must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end

   logic          tgt;
   logic [WW-1:0] wt;

   vsw_keypath #(.ADV_CYC(ADV_CYC)) u_key (
      .clk(clk), .rst_n(rst_n),
      .key_i(key_i), .dkey_i(dkey_i), .act_i(act_i),
      .hw_en_i(hw_en_i), .pass_i(pass_i), .adv_i(adv_i),
      .tgt_o(tgt)
   );

   vsw_ramp #(.STEPS(STEPS)) u_ramp (
      .clk(clk), .rst_n(rst_n), .tgt_i(tgt), .wt_o(wt)
   );

   vsw_blend #(.DATA_W(DATA_W), .STEPS(STEPS), .ADV_CYC(ADV_CYC)) u_blend (
      .clk(clk), .rst_n(rst_n),
      .enc_i(enc_i), .cvbs_i(cvbs_i), .wt_i(wt), .comp_o(comp_o)
   );
endmodule

// File: tb/test_vsw_soft_key_switch.sv
`timescale 1ns/1ps
module test_vsw_soft_key_switch;
   localparam int DW  = 10;
   localparam int ADV = 5;
   localparam int S   = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] enc_i = '0, cvbs_i = '0;
   logic          key_i = 1'b0, dkey_i = 1'b0, act_i = 1'b0;
   logic          hw_en_i = 1'b0, pass_i = 1'b0, adv_i = 1'b0;
   logic [DW-1:0] comp_o;

   always #4 clk = ~clk;

   vsw_soft_key_switch #(.DATA_W(DW), .STEPS(S), .ADV_CYC(ADV)) i_vsw_soft_key_switch (
      .clk(clk), .rst_n(rst_n), .enc_i(enc_i), .cvbs_i(cvbs_i),
      .key_i(key_i), .dkey_i(dkey_i), .act_i(act_i),
      .hw_en_i(hw_en_i), .pass_i(pass_i), .adv_i(adv_i), .comp_o(comp_o)
   );

   int    vectors = 0, miscompares = 0;
   string req = "R1";
   bit    done = 1'b0;

   // reference model state
   int he[64], hc[64];
   bit hk[64], hd[64], ha[64];
   int kk = 0, wm = 0, out_exp = 0;

   function automatic bit ok(int j);
      return j >= 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) begin
            he[i] = 0; hc[i] = 0; hk[i] = 0; hd[i] = 0; ha[i] = 0;
         end
         kk = 0; wm = 0; out_exp = 0;
      end else begin
         int jd, jk, jn;
         bit ks, dk, ac, t;
         jd = kk - 1 - ADV - S / 2;
         out_exp = (wm * (ok(jd) ? hc[jd % 64] : 0)
                  + (S - wm) * (ok(jd) ? he[jd % 64] : 0) + S / 2) / S;
         jn = kk - 1 - ADV;
         jk = adv_i ? kk - 1 : jn;
         ks = ok(jk) ? hk[jk % 64] : 1'b0;
         dk = ok(jn) ? hd[jn % 64] : 1'b0;
         ac = ok(jn) ? ha[jn % 64] : 1'b0;
         t  = ((hw_en_i & ks) | dk) & (ac | pass_i);
         if (t && wm < S) wm = wm + 1;
         else if (!t && wm > 0) wm = wm - 1;
         he[kk % 64] = int'(enc_i); hc[kk % 64] = int'(cvbs_i);
         hk[kk % 64] = key_i; hd[kk % 64] = dkey_i; ha[kk % 64] = act_i;
         kk = kk + 1;
      end
   end

   task automatic cycd(input bit k, input bit d, input bit a,
                       input logic [DW-1:0] e, input logic [DW-1:0] c);
      @(negedge clk);
      vectors++;
      if (comp_o !== DW'(out_exp)) begin
         miscompares++;
         $display("FAIL %s: comp_o=%0d expected %0d (vector %0d)", req, comp_o, out_exp, vectors);
      end
      key_i = k; dkey_i = d; act_i = a; enc_i = e; cvbs_i = c;
   endtask

   task automatic cyc(input bit k, input bit d, input bit a);
      cycd(k, d, a, DW'($urandom), DW'($urandom));
   endtask

   initial begin
      // R1: reset value and first clock afterwards
      req = "R1";
      repeat (4) cyc(0, 0, 1);
      rst_n = 1'b1;
      hw_en_i = 1'b1;
      repeat (2) cyc(0, 0, 1);
      req = "R2";
      repeat (20) cyc(0, 0, 1);
      req = "R3";
      repeat (20) cyc(1, 0, 1);
      repeat (12) cyc(0, 0, 1);
      // R4: rounding with fixed source pairs
      req = "R4";
      repeat (10) cycd(1, 0, 1, 10'd0, 10'd1);
      repeat (10) cycd(0, 0, 1, 10'd0, 10'd1);
      repeat (10) cycd(1, 0, 1, 10'd1023, 10'd0);
      repeat (10) cycd(0, 0, 1, 10'd1023, 10'd0);
      repeat (10) cycd(1, 0, 1, 10'd3, 10'd1020);
      repeat (12) cycd(0, 0, 1, 10'd3, 10'd1020);
      // R5: isolated pulses place the half-weight slot
      req = "R5";
      for (int p = 1; p <= 3; p++) begin
         repeat (p) cyc(1, 0, 1);
         repeat (12) cyc(0, 0, 1);
      end
      // R11: reversals mid-ramp
      req = "R11";
      for (int i = 0; i < 40; i++) cyc(i % 2 == 0, 0, 1);
      for (int i = 0; i < 40; i++) cyc(i % 3 != 0, 0, 1);
      repeat (12) cyc(0, 0, 1);
      // R7: hardware key disabled
      req = "R7";
      hw_en_i = 1'b0;
      for (int i = 0; i < 30; i++) cyc((i / 4) % 2 == 0, 0, 1);
      repeat (12) cyc(0, 0, 1);
      hw_en_i = 1'b1;
      // R8: active-video gating of both keys
      req = "R8";
      for (int i = 0; i < 40; i++) cyc(1, 0, (i / 7) % 2 == 1);
      for (int i = 0; i < 30; i++) cyc(0, 1, (i / 5) % 2 == 1);
      repeat (12) cyc(0, 0, 1);
      // R9: blanking pass-through
      req = "R9";
      pass_i = 1'b1;
      for (int i = 0; i < 30; i++) cyc((i / 6) % 2 == 0, 0, 0);
      repeat (12) cyc(0, 0, 0);
      pass_i = 1'b0;
      // R10: data key ORed, works with hardware key disabled
      req = "R10";
      hw_en_i = 1'b0;
      for (int i = 0; i < 30; i++) cyc(1, (i / 5) % 2 == 0, 1);
      repeat (12) cyc(0, 0, 1);
      hw_en_i = 1'b1;
      // R6: advanced external key, data key stays aligned
      req = "R6";
      adv_i = 1'b1;
      for (int p = 1; p <= 2; p++) begin
         repeat (p) cyc(1, 0, 1);
         repeat (14) cyc(0, 0, 1);
      end
      for (int i = 0; i < 30; i++) cyc(i % 9 == 0, i % 11 == 3, 1);
      repeat (14) cyc(0, 0, 1);
      adv_i = 1'b0;
      // R12: everything random
      req = "R12";
      for (int i = 0; i < 150; i++) begin
         hw_en_i = 1'($urandom); pass_i = 1'($urandom); adv_i = 1'($urandom);
         cyc(1'($urandom), 1'($urandom), 1'($urandom));
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule